// File: doc/BRIEF.md
# Infrared nibble-frame decoder

This block turns a stream of measured infrared pulse and space durations into remote-control key events for a frame format that carries sixteen 4-bit nibbles. Each nibble is sent as a space whose length grows with the nibble value. The frame is split into two halves of eight nibbles by a long gap and is closed by a longer trailer space. Each event reaches the block as a duration in microseconds, a flag that marks it as a pulse or a space, a one-cycle valid strobe, and a flag that asks the decoder to drop whatever frame it is part way through.

The block checks every event against the leader, nibble, half-gap and trailer timings and keeps the raw nibble durations. When the trailer arrives it runs a small shift-and-subtract divider. A scale factor comes from a reference nibble that always carries the value 15, and every stored duration is then turned into a nibble value with that factor. Each half must pass a mod-16 checksum, and a subaddress sent twice must match. A good frame gives a keydown strobe with a 32-bit scancode, or a repeat strobe when its toggle nibble is not zero. A bad frame gives an error strobe.

Top module: `ir_nib_frame_dec`

## Requirements
- R1: After reset, busy and all three result strobes are low, the scancode is zero and the vendor flag is low.
- R2: A pulse is a leader only when 142 < duration < 278 us (strict bounds). In idle, a leader starts a frame with the nibble count cleared. In idle, other pulses are dropped without an error. While waiting for a leader inside a frame, a pulse outside the window is dropped without an error and the state does not change.
- R3: While waiting for a space, the space is classed with strict bounds: above 19240 us it is a trailer, above 13040 us a half gap, above 624 us a nibble. A nibble's raw duration is stored at the current count, the count goes up by one, and the block waits for a leader. A space of 624 us or less raises the error strobe.
- R4: A space in idle, a space while waiting for a leader, or a pulse while waiting for a space raises the error strobe and returns the block to idle.
- R5: A nibble space that arrives when 16 nibbles are already stored raises the error strobe.
- R6: A half gap seen with 16 nibbles stored sets the count back to 8. With any count, the half gap makes the block wait for a leader.
- R7: A trailer with a stored count other than 16 raises the error strobe.
- R8: The offset of a duration is (duration − 760) when that is positive, and 0 otherwise. The divider is offset(nibble 3) / 15, truncated. A divider below DIV_MIN (default 50) raises the error strobe.
- R9: Each nibble value is the low 4 bits of offset / divider. Within each half (nibbles 0–7 and 8–15) the sum of the values mod 16 must be 0; otherwise the error strobe is raised.
- R10: The byte {nibble 0, nibble 2} must equal {nibble 8, nibble 11}; otherwise the error strobe is raised.
- R11: The scancode is {n6,n7} in bits 31:24, {n0,n2} in bits 23:16, {n12,n13} in bits 15:8 and {n14,n15} in bits 7:0. If nibble 10 is 0, the key strobe pulses for one cycle and the scancode is updated. Otherwise the repeat strobe pulses and the scancode is left unchanged. At most one of the three strobes is high in any cycle.
- R12: On every accepted frame, the vendor flag is set to whether {n4,n5} differs from 0x44. The flag never causes a rejection.
- R13: Busy is high from the cycle after the trailer is accepted until the result strobe. Events presented while busy is high are ignored.
- R14: A valid event with the clear flag set returns the block to idle without an error, whatever its polarity or duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | One-cycle strobe for a new event |
| ev_pulse | input | 1 | 1 = pulse (carrier on), 0 = space |
| ev_clear | input | 1 | Event is a decoder-clear request |
| ev_dur | input | DUR_W | Event duration in microseconds |
| busy | output | 1 | Decode arithmetic running; events ignored |
| key_valid | output | 1 | Keydown strobe |
| key_code | output | 32 | Scancode of the last keydown |
| rpt_valid | output | 1 | Repeat strobe |
| err_valid | output | 1 | Error strobe for a rejected event or frame |
| oem_flag | output | 1 | Vendor byte of last accepted frame was not 0x44 |

## Verification
The bench probes each timing edge one microsecond on either side: the leader window at 142/143 and 277/278, the nibble floor at 624/625, and a space of 19240 against 19241. A decoder with a closed bound or an off-by-one compare would swap an error for silence there. It replays a frame whose second half is overwritten after a 19240 us gap. A design that did not rewind the count to 8, or that took that gap as a trailer, would reject the frame or report a wrong code. Divider steps of 40 and 50 probe the rejection limit. Frames with corrupted nibbles, a mismatched subaddress, a broken checksum, a foreign vendor byte and non-zero toggles are checked against a bench model of the arithmetic. Events driven during the decode must leave no trace.

// File: rtl/ir_nib_pkg.sv
package ir_nib_pkg;

    localparam int DUR_W     = 16;
    localparam int NIB_N     = 16;
    localparam int NIB_W     = 4;
    localparam int REF_IDX   = 3;
    localparam int REF_VAL   = 15;
    localparam int LEAD_US   = 210;
    localparam int UNIT_US   = 136;
    localparam int PREFIX_US = 760;
    localparam int HALF_US   = 13800;
    localparam int TRAIL_US  = 20000;
    localparam int DIV_MIN   = 50;
    localparam logic [7:0] OEM_EXP = 8'h44;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_LEAD,
        CAP_SPACE
    } cap_st_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_KDIV,
        SEQ_NDIV,
        SEQ_EVAL
    } seq_st_t;

    typedef logic [NIB_N-1:0][NIB_W-1:0] nib_vec_t;

    typedef struct packed {
        logic       ok;
        logic [7:0] addr;
        logic [7:0] sub;
        logic [7:0] oem;
        logic [3:0] tog;
        logic [7:0] obc1;
        logic [7:0] obc2;
    } frame_t;

    // mod-16 sum of the eight nibbles starting at base
    function automatic logic [NIB_W-1:0] half_sum(input nib_vec_t n, input int base);
        logic [NIB_W-1:0] s;
        s = '0;
        for (int i = 0; i < NIB_N / 2; i++) begin
            s = s + n[base + i];
        end
        return s;
    endfunction

    function automatic frame_t unpack_frame(input nib_vec_t n);
        frame_t f;
        f.sub  = {n[0], n[2]};
        f.oem  = {n[4], n[5]};
        f.addr = {n[6], n[7]};
        f.tog  = n[10];
        f.obc1 = {n[12], n[13]};
        f.obc2 = {n[14], n[15]};
        f.ok   = (half_sum(n, 0) == '0) && (half_sum(n, NIB_N / 2) == '0)
                 && (f.sub == {n[8], n[11]});
        return f;
    endfunction

endpackage

// File: rtl/ir_seq_div.sv
module ir_seq_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem;
    logic [W-1:0]  dvs;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    shifted;
    logic [W-1:0]  diff;
    logic          ge;

    always_comb begin
        shifted = {rem, quo[W-1]};
        ge      = shifted >= {1'b0, dvs};
        diff    = shifted[W-1:0] - dvs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            dvs  <= '0;
            quo  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem <= '0;
                quo <= num;
                dvs <= den;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                rem <= ge ? diff : shifted[W-1:0];
                quo <= {quo[W-2:0], ge};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ir_nib_capture.sv
module ir_nib_capture
    import ir_nib_pkg::*;
#(
    parameter int DUR_W     = ir_nib_pkg::DUR_W,
    parameter int NIB_N     = ir_nib_pkg::NIB_N,
    parameter int LEAD_US   = ir_nib_pkg::LEAD_US,
    parameter int UNIT_US   = ir_nib_pkg::UNIT_US,
    parameter int PREFIX_US = ir_nib_pkg::PREFIX_US,
    parameter int HALF_US   = ir_nib_pkg::HALF_US,
    parameter int TRAIL_US  = ir_nib_pkg::TRAIL_US
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ev_acc,
    input  logic                         ev_pulse,
    input  logic                         ev_clear,
    input  logic [DUR_W-1:0]             ev_dur,
    output logic                         frame_ready,
    output logic                         cap_err,
    output logic [NIB_N-1:0][DUR_W-1:0]  dur_q
);
    localparam int CW       = $clog2(NIB_N + 1);
    localparam int IW       = $clog2(NIB_N);
    localparam int LEAD_LO  = LEAD_US - UNIT_US / 2;
    localparam int LEAD_HI  = LEAD_US + UNIT_US / 2;
    localparam int TRL_MIN  = TRAIL_US - PREFIX_US;
    localparam int HLF_MIN  = HALF_US - PREFIX_US;
    localparam int NIB_MIN  = PREFIX_US - UNIT_US;

    cap_st_t       st;
    logic [CW-1:0] cnt;
    logic          lead_ok, is_trl, is_half, is_nib, full;

    always_comb begin
        lead_ok = (ev_dur > DUR_W'(LEAD_LO)) && (ev_dur < DUR_W'(LEAD_HI));
        is_trl  = ev_dur > DUR_W'(TRL_MIN);
        is_half = ev_dur > DUR_W'(HLF_MIN);
        is_nib  = ev_dur > DUR_W'(NIB_MIN);
        full    = cnt == CW'(NIB_N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= CAP_IDLE;
            cnt         <= '0;
            frame_ready <= 1'b0;
            cap_err     <= 1'b0;
            dur_q       <= '0;
        end else begin
            frame_ready <= 1'b0;
            cap_err     <= 1'b0;
            if (ev_acc) begin
                if (ev_clear) begin
                    st <= CAP_IDLE;
                end else begin
                    case (st)
                        CAP_IDLE: begin
                            if (!ev_pulse) begin
                                cap_err <= 1'b1;
                            end else if (lead_ok) begin
                                cnt <= '0;
                                st  <= CAP_SPACE;
                            end
                        end
                        CAP_LEAD: begin
                            if (!ev_pulse) begin
                                cap_err <= 1'b1;
                                st      <= CAP_IDLE;
                            end else if (lead_ok) begin
                                st <= CAP_SPACE;
                            end
                        end
                        CAP_SPACE: begin
                            if (ev_pulse) begin
                                cap_err <= 1'b1;
                                st      <= CAP_IDLE;
                            end else if (is_trl) begin
                                st <= CAP_IDLE;
                                if (full) frame_ready <= 1'b1;
                                else      cap_err     <= 1'b1;
                            end else if (is_half) begin
                                st <= CAP_LEAD;
                                if (full) cnt <= CW'(NIB_N / 2);
                            end else if (is_nib) begin
                                if (full) begin
                                    cap_err <= 1'b1;
                                    st      <= CAP_IDLE;
                                end else begin
                                    dur_q[cnt[IW-1:0]] <= ev_dur;
                                    cnt <= cnt + 1'b1;
                                    st  <= CAP_LEAD;
                                end
                            end else begin
                                cap_err <= 1'b1;
                                st      <= CAP_IDLE;
                            end
                        end
                        default: st <= CAP_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ir_nib_frame_dec.sv
module ir_nib_frame_dec
    import ir_nib_pkg::*;
#(
    parameter int DUR_W     = ir_nib_pkg::DUR_W,
    parameter int DIV_MIN   = ir_nib_pkg::DIV_MIN,
    parameter int LEAD_US   = ir_nib_pkg::LEAD_US,
    parameter int UNIT_US   = ir_nib_pkg::UNIT_US,
    parameter int PREFIX_US = ir_nib_pkg::PREFIX_US,
    parameter int HALF_US   = ir_nib_pkg::HALF_US,
    parameter int TRAIL_US  = ir_nib_pkg::TRAIL_US
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic             ev_pulse,
    input  logic             ev_clear,
    input  logic [DUR_W-1:0] ev_dur,
    output logic             busy,
    output logic             key_valid,
    output logic [31:0]      key_code,
    output logic             rpt_valid,
    output logic             err_valid,
    output logic             oem_flag
);
    localparam int IW = $clog2(NIB_N);

    logic                        frame_ready, cap_err, seq_err;
    logic [NIB_N-1:0][DUR_W-1:0] dur_q;
    seq_st_t                     seq;
    logic [IW-1:0]               idx, idx_nx;
    logic                        div_go, div_done;
    logic [DUR_W-1:0]            div_num, div_den, div_q;
    nib_vec_t                    nib;
    frame_t                      fr;

    function automatic logic [DUR_W-1:0] f_off(input logic [DUR_W-1:0] d);
        return (d > DUR_W'(PREFIX_US)) ? d - DUR_W'(PREFIX_US) : '0;
    endfunction

    assign busy      = (seq != SEQ_IDLE) || frame_ready;
    assign err_valid = cap_err || seq_err;
    assign idx_nx    = idx + 1'b1;
    assign fr        = unpack_frame(nib);

    ir_nib_capture #(
        .DUR_W(DUR_W), .NIB_N(NIB_N), .LEAD_US(LEAD_US), .UNIT_US(UNIT_US),
        .PREFIX_US(PREFIX_US), .HALF_US(HALF_US), .TRAIL_US(TRAIL_US)
    ) u_cap (
        .clk(clk), .rst(rst), .ev_acc(ev_valid && !busy), .ev_pulse(ev_pulse),
        .ev_clear(ev_clear), .ev_dur(ev_dur), .frame_ready(frame_ready),
        .cap_err(cap_err), .dur_q(dur_q)
    );

    ir_seq_div #(.W(DUR_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
        .done(div_done), .quo(div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seq       <= SEQ_IDLE;
            idx       <= '0;
            div_go    <= 1'b0;
            div_num   <= '0;
            div_den   <= '0;
            nib       <= '0;
            key_valid <= 1'b0;
            rpt_valid <= 1'b0;
            seq_err   <= 1'b0;
            key_code  <= '0;
            oem_flag  <= 1'b0;
        end else begin
            div_go    <= 1'b0;
            key_valid <= 1'b0;
            rpt_valid <= 1'b0;
            seq_err   <= 1'b0;
            case (seq)
                SEQ_IDLE: begin
                    if (frame_ready) begin
                        div_num <= f_off(dur_q[REF_IDX]);
                        div_den <= DUR_W'(REF_VAL);
                        div_go  <= 1'b1;
                        seq     <= SEQ_KDIV;
                    end
                end
                SEQ_KDIV: begin
                    if (div_done) begin
                        if (div_q < DUR_W'(DIV_MIN)) begin
                            seq_err <= 1'b1;
                            seq     <= SEQ_IDLE;
                        end else begin
                            div_den <= div_q;
                            div_num <= f_off(dur_q[0]);
                            idx     <= '0;
                            div_go  <= 1'b1;
                            seq     <= SEQ_NDIV;
                        end
                    end
                end
                SEQ_NDIV: begin
                    if (div_done) begin
                        nib[idx] <= div_q[NIB_W-1:0];
                        if (idx == IW'(NIB_N - 1)) begin
                            seq <= SEQ_EVAL;
                        end else begin
                            idx     <= idx_nx;
                            div_num <= f_off(dur_q[idx_nx]);
                            div_go  <= 1'b1;
                        end
                    end
                end
                SEQ_EVAL: begin
                    if (!fr.ok) begin
                        seq_err <= 1'b1;
                    end else begin
                        oem_flag <= fr.oem != OEM_EXP;
                        if (fr.tog == '0) begin
                            key_valid <= 1'b1;
                            key_code  <= {fr.addr, fr.sub, fr.obc1, fr.obc2};
                        end else begin
                            rpt_valid <= 1'b1;
                        end
                    end
                    seq <= SEQ_IDLE;
                end
                default: seq <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ir_nib_frame_dec_chk.sv
module ir_nib_frame_dec_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        key_valid,
    input logic        rpt_valid,
    input logic        err_valid,
    input logic [31:0] key_code
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({key_valid, rpt_valid, err_valid})); // R11
    AST_KEY_PULSE: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid); // R11
    AST_RPT_PULSE: assert property (@(posedge clk) disable iff (rst)
        rpt_valid |=> !rpt_valid); // R11
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !key_valid |-> $stable(key_code)); // R11
    AST_RESULT_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        (key_valid || rpt_valid) |-> $past(busy)); // R13
    AST_BUSY_ENDS_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (key_valid || rpt_valid || err_valid)); // R13
endmodule

bind ir_nib_frame_dec ir_nib_frame_dec_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .key_valid(key_valid),
    .rpt_valid(rpt_valid), .err_valid(err_valid), .key_code(key_code)
);

// File: tb/ir_nib_frame_dec_tb.sv
`timescale 1ns/1ps
module ir_nib_frame_dec_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0, ev_pulse = 1'b0, ev_clear = 1'b0;
    logic [15:0] ev_dur = '0;
    logic        busy, key_valid, rpt_valid, err_valid, oem_flag;
    logic [31:0] key_code;

    int n_chk = 0, n_fail = 0;
    int n_key = 0, n_rpt = 0, n_err = 0;
    logic [31:0] last_code = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ir_nib_frame_dec u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_pulse(ev_pulse),
        .ev_clear(ev_clear), .ev_dur(ev_dur), .busy(busy), .key_valid(key_valid),
        .key_code(key_code), .rpt_valid(rpt_valid), .err_valid(err_valid),
        .oem_flag(oem_flag)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (key_valid) begin n_key++; last_code = key_code; end
            if (rpt_valid) n_rpt++;
            if (err_valid) n_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ev(input bit p, input int d, input bit c = 0);
        @(negedge clk);
        while (busy) @(negedge clk);
        ev_valid = 1; ev_pulse = p; ev_dur = 16'(d); ev_clear = c;
        @(negedge clk);
        ev_valid = 0; ev_clear = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic clr();
        ev(0, 0, 1);
    endtask

    task automatic make_frame(input int addr, input int sub, input int o1, input int o2,
                              input int oem, input int tog, input int step, input int jit,
                              output int unsigned d[16]);
        int n[16];
        int s;
        n[0] = sub >> 4; n[2] = sub & 15; n[3] = 15;
        n[4] = oem >> 4; n[5] = oem & 15; n[6] = addr >> 4; n[7] = addr & 15;
        n[8] = sub >> 4; n[10] = tog; n[11] = sub & 15;
        n[12] = o1 >> 4; n[13] = o1 & 15; n[14] = o2 >> 4; n[15] = o2 & 15;
        s = n[0] + n[2] + n[3] + n[4] + n[5] + n[6] + n[7];
        n[1] = (16 - (s % 16)) % 16;
        s = n[8] + n[10] + n[11] + n[12] + n[13] + n[14] + n[15];
        n[9] = (16 - (s % 16)) % 16;
        for (int i = 0; i < 16; i++) begin
            d[i] = 760 + n[i] * step + ((jit > 0) ? ($urandom % jit) : 0);
        end
    endtask

    // kind: 0 error, 1 keydown, 2 repeat
    task automatic model(input int unsigned d[16], output int kind,
                         output logic [31:0] code, output bit oem);
        int unsigned k, off;
        int n[16];
        int s1, s2;
        kind = 0; code = '0; oem = 0;
        off = (d[3] > 760) ? d[3] - 760 : 0;
        k = off / 15;
        if (k < 50) return;
        s1 = 0; s2 = 0;
        for (int i = 0; i < 16; i++) begin
            off = (d[i] > 760) ? d[i] - 760 : 0;
            n[i] = (off / k) % 16;
            if (i < 8) s1 += n[i]; else s2 += n[i];
        end
        if ((s1 % 16) != 0 || (s2 % 16) != 0) return;
        if ((n[0] * 16 + n[2]) != (n[8] * 16 + n[11])) return;
        code = {8'(n[6] * 16 + n[7]), 8'(n[0] * 16 + n[2]),
                8'(n[12] * 16 + n[13]), 8'(n[14] * 16 + n[15])};
        oem = (n[4] * 16 + n[5]) != 8'h44;
        kind = (n[10] == 0) ? 1 : 2;
    endtask

    task automatic send_half(input int unsigned d[16], input int base);
        for (int i = base; i < base + 8; i++) begin
            ev(0, int'(d[i]));
            ev(1, 210);
        end
    endtask

    task automatic send_frame(input int unsigned d[16]);
        ev(1, 210);
        send_half(d, 0);
        ev(0, 13800);
        ev(1, 210);
        send_half(d, 8);
        ev(0, 20000);
    endtask

    task automatic expect_result(input int kind, input logic [31:0] code, input bit oem,
                                 input int k0, input int r0, input int e0,
                                 input logic [31:0] c0, input string tag);
        chk((n_err - e0) == (kind == 0 ? 1 : 0), {tag, " error count"}, n_err - e0, kind == 0);
        chk((n_key - k0) == (kind == 1 ? 1 : 0), {tag, " key count"}, n_key - k0, kind == 1);
        chk((n_rpt - r0) == (kind == 2 ? 1 : 0), {tag, " repeat count"}, n_rpt - r0, kind == 2);
        if (kind == 1) chk(last_code == code, {tag, " R11 scancode"}, last_code, code);
        if (kind == 2) chk(key_code == c0, {tag, " R11 code held on repeat"}, key_code, c0);
        if (kind != 0) chk(oem_flag == oem, {tag, " R12 vendor flag"}, oem_flag, oem);
    endtask

    task automatic run_frame(input int unsigned d[16], input string tag);
        int kind, k0, r0, e0;
        logic [31:0] code, c0;
        bit oem;
        model(d, kind, code, oem);
        k0 = n_key; r0 = n_rpt; e0 = n_err; c0 = key_code;
        send_frame(d);
        settle();
        expect_result(kind, code, oem, k0, r0, e0, c0, tag);
    endtask

    task automatic err_delta(input int e0, input int exp, input string tag);
        settle();
        chk((n_err - e0) == exp, tag, n_err - e0, exp);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned da[16], db[16];
        int e0, k0, kind;
        logic [31:0] code;
        bit oem;
        void'($urandom(32'h1A2B3C));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !key_valid && !rpt_valid && !err_valid && !oem_flag && key_code == 0,
            "R1 reset outputs", {busy, key_valid, rpt_valid, err_valid, oem_flag}, 0);

        // R11 R12 keydown with expected vendor byte
        make_frame(8'hA5, 8'h3C, 8'h12, 8'hF0, 8'h44, 0, 136, 0, da);
        run_frame(da, "R11 R3 keydown");
        // R11 repeat
        make_frame(8'h11, 8'h3C, 8'h22, 8'h33, 8'h44, 9, 136, 0, da);
        run_frame(da, "R11 repeat");
        // R12 foreign vendor byte
        make_frame(8'h5A, 8'h01, 8'h80, 8'h7F, 8'h12, 0, 136, 0, da);
        run_frame(da, "R12 vendor");
        // R9 checksum broken
        make_frame(8'h5A, 8'h01, 8'h80, 8'h7F, 8'h44, 0, 136, 0, da);
        da[1] += 136;
        run_frame(da, "R9 checksum");
        // R10 subaddress mismatch with checksum repaired
        make_frame(8'h5A, 8'h01, 8'h80, 8'h7F, 8'h44, 0, 136, 0, da);
        da[11] += 136; da[9] = (da[9] - 760 == 0) ? 760 + 15 * 136 : da[9] - 136;
        run_frame(da, "R10 subaddress");
        // R8 divider below and at the limit
        make_frame(8'h33, 8'h44, 8'h55, 8'h66, 8'h44, 0, 40, 0, da);
        run_frame(da, "R8 divider 40");
        make_frame(8'h33, 8'h44, 8'h55, 8'h66, 8'h44, 0, 50, 0, da);
        run_frame(da, "R8 divider 50");
        // R8 offset saturates: nibble durations below 760 read as zero
        make_frame(8'h70, 8'h00, 8'h00, 8'h00, 8'h44, 0, 136, 0, da);
        for (int i = 0; i < 16; i++) if (da[i] == 760) da[i] = 700;
        run_frame(da, "R8 saturating offset");

        // R2 leader window bounds
        clr(); e0 = n_err; ev(1, 142); ev(0, 1000); err_delta(e0, 1, "R2 leader 142 ignored");
        clr(); e0 = n_err; ev(1, 143); ev(0, 1000); err_delta(e0, 0, "R2 leader 143 accepted");
        clr(); e0 = n_err; ev(1, 278); ev(0, 1000); err_delta(e0, 1, "R2 leader 278 ignored");
        clr(); e0 = n_err; ev(1, 277); ev(0, 1000); err_delta(e0, 0, "R2 leader 277 accepted");
        // R2 bad pulse while waiting for a leader is dropped
        clr(); e0 = n_err; ev(1, 210); ev(0, 900); ev(1, 500); ev(1, 210); ev(0, 900);
        err_delta(e0, 0, "R2 stray pulse in frame");
        // R3 nibble floor
        clr(); e0 = n_err; ev(1, 210); ev(0, 624); err_delta(e0, 1, "R3 space 624");
        clr(); e0 = n_err; ev(1, 210); ev(0, 625); err_delta(e0, 0, "R3 space 625");
        // R4 polarity
        clr(); e0 = n_err; ev(0, 900); err_delta(e0, 1, "R4 space in idle");
        clr(); e0 = n_err; ev(1, 210); ev(1, 210); err_delta(e0, 1, "R4 pulse awaiting space");
        clr(); e0 = n_err; ev(1, 210); ev(0, 900); ev(0, 900); err_delta(e0, 1, "R4 space awaiting leader");
        // R7 short frame trailer
        clr(); e0 = n_err; ev(1, 210); ev(0, 900); ev(1, 210); ev(0, 900); ev(1, 210); ev(0, 20000);
        err_delta(e0, 1, "R7 trailer with count 2");
        // R5 seventeenth nibble
        make_frame(8'h12, 8'h34, 8'h56, 8'h78, 8'h44, 0, 136, 0, da);
        clr(); e0 = n_err; k0 = n_key;
        ev(1, 210); send_half(da, 0); ev(0, 13800); ev(1, 210); send_half(da, 8); ev(0, 900);
        err_delta(e0, 1, "R5 seventeenth nibble");
        chk(n_key == k0, "R5 no key", n_key - k0, 0);
        // R6 R3 19240 is a half gap that rewinds to 8; 19241 is the trailer
        make_frame(8'hC3, 8'h96, 8'h0F, 8'hE1, 8'h44, 0, 136, 0, da);
        make_frame(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 5, 136, 0, db);
        clr(); e0 = n_err; k0 = n_key;
        ev(1, 210); send_half(da, 0); ev(0, 13800); ev(1, 210); send_half(db, 8);
        ev(0, 19240); ev(1, 210); send_half(da, 8); ev(0, 19241);
        settle();
        model(da, kind, code, oem);
        chk(n_err == e0, "R6 no error on rewind", n_err - e0, 0);
        chk(n_key - k0 == 1, "R6 key after rewind", n_key - k0, 1);
        chk(last_code == code, "R6 R3 code from second half", last_code, code);
        // R14 clear mid frame
        clr(); e0 = n_err; ev(1, 210); clr();
        settle(); chk(n_err == e0, "R14 clear gives no error", n_err - e0, 0);
        ev(0, 900); err_delta(e0, 1, "R14 idle after clear");
        // R13 busy and ignored events
        make_frame(8'h21, 8'h43, 8'h65, 8'h87, 8'h44, 0, 136, 0, da);
        model(da, kind, code, oem);
        clr(); e0 = n_err; k0 = n_key;
        send_frame(da);
        chk(busy == 1'b1, "R13 busy after trailer", busy, 1);
        ev_valid = 1; ev_pulse = 1; ev_dur = 16'd210;
        repeat (20) @(negedge clk);
        ev_valid = 0; ev_pulse = 0;
        settle();
        chk(n_key - k0 == 1 && last_code == code, "R13 frame unaffected", last_code, code);
        ev(0, 900); err_delta(e0, 1, "R13 leader during busy ignored");

        // random frames
        for (int t = 0; t < 40; t++) begin
            int tog, oemv, step, jit;
            tog  = (($urandom % 4) == 0) ? 1 + ($urandom % 15) : 0;
            oemv = (($urandom % 3) == 0) ? ($urandom % 256) : 8'h44;
            step = 130 + ($urandom % 12);
            jit  = $urandom % 25;
            make_frame($urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256,
                       oemv, tog, step, jit, da);
            if (($urandom % 8) == 0) da[$urandom % 16] += step;
            clr();
            run_frame(da, "R9 R11 random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
        $finish;
    end
endmodule